// File: doc/BRIEF.md
# Level-Sensitive Main Interrupt Controller

This block gathers interrupt sources in banks of 32. Each bank shows the live, synchronized level of its sources in a cause register. Three enable masks in the same bank decide which of those levels reach three separate outputs: a normal interrupt line, a fast interrupt line and an endpoint line. Nothing is latched, so there is no acknowledge. A source stays visible in the cause register for as long as its input is held high. Software reads the cause register, ANDs it with its own copy of a mask and scans the pending bits itself.

Several identical banks sit side by side. Bank `b` serves sources `32*b` to `32*b+31` and answers at byte base `0x10*b`. A plain register bus with a write strobe and a read strobe reaches every register. Read data is registered.

Top module: `intc_main_top`

## Requirements
- R1: After reset every mask register reads 0, every cause register reads 0 and all three outputs of every bank are low.
- R2: A cause bit equals its source input level after a two-flop synchronizer. A level applied before clock edge n is readable after edge n+2, and it stays visible without any acknowledge write.
- R3: The normal interrupt output of a bank is high exactly when the bitwise AND of that bank's cause and its normal mask (byte offset 0x04) is nonzero.
- R4: The fast interrupt output of a bank is high exactly when the AND of cause and the fast mask (offset 0x08) is nonzero.
- R5: The endpoint output of a bank is high exactly when the AND of cause and the endpoint mask (offset 0x0c) is nonzero.
- R6: A mask bit written as 1 enables its source and a bit written as 0 disables it. Each mask reads back the value last written. Writing 0 to the normal mask drops the normal output on the next cycle.
- R7: Writes to the cause register (offset 0x00) are ignored: no mask changes and the cause value still follows the sources.
- R8: Reads of an offset whose low nibble is not 0x0, 0x4, 0x8 or 0xc, or whose bank index (address bits above bit 3) is at or beyond the bank count, return 0. Writes there change no register.
- R9: Banks are independent: bank b's registers sit at 0x10*b and see only sources 32*b..32*b+31, and its outputs use only its own masks.
- R10: Read data appears on `bus_rdata` one cycle after the read strobe and holds its value in every cycle with no read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_BANKS*32 | Level-sensitive interrupt sources, bank b in bits 32*b+31:32*b |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address: bank index in the bits above bit 3, register offset in bits 3:0 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | NUM_BANKS | Normal interrupt output per bank |
| fiq_o | output | NUM_BANKS | Fast interrupt output per bank |
| endp_o | output | NUM_BANKS | Endpoint output per bank |

## Verification
The assertions check the following properties on every cycle:
- No output of a bank rises unless one of its own sources was high two edges earlier.
- A zero write to a normal mask drops that bank's line at once.
- Unmapped reads return zero.
- Read data holds between read strobes.

The bench's scenarios cover the rest, by walking a single source through every bit of every bank under distinct mask patterns:
- The exact OR-of-AND output values.
- Mask readback.
- The synchronizer latency.
- That cause writes and unmapped writes leave the registers untouched.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int SRC_PER_BANK = 32;
    localparam int REG_W        = 32;

    typedef enum logic [2:0] {
        SEL_CAUSE,
        SEL_IRQ,
        SEL_FIQ,
        SEL_ENDP,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic [REG_W-1:0] irq;
        logic [REG_W-1:0] fiq;
        logic [REG_W-1:0] endp;
    } bank_masks_t;

    typedef struct packed {
        logic irq;
        logic fiq;
        logic endp;
    } bank_lines_t;

    function automatic reg_sel_e decode_offset(input logic [3:0] off);
        case (off)
            4'h0:    return SEL_CAUSE;
            4'h4:    return SEL_IRQ;
            4'h8:    return SEL_FIQ;
            4'hc:    return SEL_ENDP;
            default: return SEL_NONE;
        endcase
    endfunction

    function automatic logic any_enabled(input logic [REG_W-1:0] cause,
                                         input logic [REG_W-1:0] mask);
        return |(cause & mask);
    endfunction

endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
        end
    end

    assign q_o = stage2_q;

endmodule

// File: rtl/intc_bank.sv
module intc_bank
    import intc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] cause_i,
    input  logic             wr_i,
    input  reg_sel_e         sel_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] rd_val_o,
    output bank_lines_t      lines_o
);

    bank_masks_t masks_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            masks_q <= '0;
        end else if (wr_i) begin
            case (sel_i)
                SEL_IRQ:  masks_q.irq  <= wdata_i;
                SEL_FIQ:  masks_q.fiq  <= wdata_i;
                SEL_ENDP: masks_q.endp <= wdata_i;
                default:  masks_q      <= masks_q;
            endcase
        end
    end

    always_comb begin
        case (sel_i)
            SEL_CAUSE: rd_val_o = cause_i;
            SEL_IRQ:   rd_val_o = masks_q.irq;
            SEL_FIQ:   rd_val_o = masks_q.fiq;
            SEL_ENDP:  rd_val_o = masks_q.endp;
            default:   rd_val_o = '0;
        endcase
    end

    always_comb begin
        lines_o.irq  = any_enabled(cause_i, masks_q.irq);
        lines_o.fiq  = any_enabled(cause_i, masks_q.fiq);
        lines_o.endp = any_enabled(cause_i, masks_q.endp);
    end

endmodule

// File: rtl/intc_main_top.sv
module intc_main_top
    import intc_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int ADDR_W    = 8
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_BANKS*SRC_PER_BANK-1:0] src_i,
    input  logic                              bus_wr,
    input  logic                              bus_rd,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic [REG_W-1:0]                  bus_wdata,
    output logic [REG_W-1:0]                  bus_rdata,
    output logic [NUM_BANKS-1:0]              irq_o,
    output logic [NUM_BANKS-1:0]              fiq_o,
    output logic [NUM_BANKS-1:0]              endp_o
);

    localparam int TOTAL_SRC  = NUM_BANKS * SRC_PER_BANK;
    localparam int BANK_IDX_W = ADDR_W - 4;

    logic [TOTAL_SRC-1:0]  src_sync;
    logic [BANK_IDX_W-1:0] bank_idx;
    reg_sel_e              sel;
    logic [REG_W-1:0]      rd_vals [NUM_BANKS];
    logic [REG_W-1:0]      rd_mux;
    logic [REG_W-1:0]      rdata_q;

    assign bank_idx = bus_addr[ADDR_W-1:4];
    assign sel      = decode_offset(bus_addr[3:0]);

    intc_sync #(.WIDTH(TOTAL_SRC)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (src_i),
        .q_o (src_sync)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic        hit;
        bank_lines_t lines;

        assign hit = (bank_idx == BANK_IDX_W'(b));

        intc_bank u_bank (
            .clk      (clk),
            .rst      (rst),
            .cause_i  (src_sync[b*SRC_PER_BANK +: SRC_PER_BANK]),
            .wr_i     (bus_wr && hit),
            .sel_i    (sel),
            .wdata_i  (bus_wdata),
            .rd_val_o (rd_vals[b]),
            .lines_o  (lines)
        );

        assign irq_o[b]  = lines.irq;
        assign fiq_o[b]  = lines.fiq;
        assign endp_o[b] = lines.endp;
    end

    always_comb begin
        rd_mux = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_idx == BANK_IDX_W'(b)) rd_mux = rd_vals[b];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (bus_rd) begin
            rdata_q <= rd_mux;
        end
    end

    assign bus_rdata = rdata_q;

endmodule

// File: rtl/intc_main_checker.sv
module intc_main_checker #(
    parameter int NUM_BANKS = 2,
    parameter int ADDR_W    = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic [NUM_BANKS*32-1:0] src_i,
    input logic                    bus_wr,
    input logic                    bus_rd,
    input logic [ADDR_W-1:0]       bus_addr,
    input logic [31:0]             bus_wdata,
    input logic [31:0]             bus_rdata,
    input logic [NUM_BANKS-1:0]    irq_o,
    input logic [NUM_BANKS-1:0]    fiq_o,
    input logic [NUM_BANKS-1:0]    endp_o
);

    logic [1:0] warm_q;
    logic       unmapped;

    always_ff @(posedge clk) begin
        if (rst)                warm_q <= 2'd0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    always_comb begin
        unmapped = !(bus_addr[3:0] == 4'h0 || bus_addr[3:0] == 4'h4 ||
                     bus_addr[3:0] == 4'h8 || bus_addr[3:0] == 4'hc) ||
                   (int'(bus_addr[ADDR_W-1:4]) >= NUM_BANKS);
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
        p_irq_src_r3: assert property (@(posedge clk) disable iff (rst)
            (warm_q >= 2'd2 && irq_o[b]) |-> (|$past(src_i[b*32 +: 32], 2)));
        p_fiq_src_r4: assert property (@(posedge clk) disable iff (rst)
            (warm_q >= 2'd2 && fiq_o[b]) |-> (|$past(src_i[b*32 +: 32], 2)));
        p_endp_src_r5: assert property (@(posedge clk) disable iff (rst)
            (warm_q >= 2'd2 && endp_o[b]) |-> (|$past(src_i[b*32 +: 32], 2)));
        p_mask_off_r6: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && bus_addr == ADDR_W'(b*16 + 4) && bus_wdata == 32'h0)
            |=> !irq_o[b]);
    end

    p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && unmapped) |=> (bus_rdata == 32'h0));

    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

endmodule

bind intc_main_top intc_main_checker #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W)
) u_checker (
    .clk       (clk),
    .rst       (rst),
    .src_i     (src_i),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o),
    .endp_o    (endp_o)
);

// File: tb/sim_intc_main_top.sv
module sim_intc_main_top;

    localparam int NB = 2;
    localparam int AW = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NB*32-1:0] src = '0;
    logic           bus_wr = 1'b0;
    logic           bus_rd = 1'b0;
    logic [AW-1:0]  bus_addr = '0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic [NB-1:0]  irq_o, fiq_o, endp_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    logic [31:0] m_irq  [NB];
    logic [31:0] m_fiq  [NB];
    logic [31:0] m_endp [NB];

    always #4 clk = ~clk;

    intc_main_top #(.NUM_BANKS(NB), .ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .src_i(src), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o), .endp_o(endp_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic set_masks(input int b, input logic [31:0] i, input logic [31:0] f,
                             input logic [31:0] e);
        bus_write(AW'(b*16 + 4), i);
        bus_write(AW'(b*16 + 8), f);
        bus_write(AW'(b*16 + 12), e);
        m_irq[b] = i; m_fiq[b] = f; m_endp[b] = e;
    endtask

    task automatic apply_src(input logic [NB*32-1:0] v);
        @(negedge clk);
        src = v;
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_lines(input string tag);
        for (int b = 0; b < NB; b++) begin
            logic [31:0] s;
            s = src[b*32 +: 32];
            check({tag, " R3 irq"},  {31'd0, irq_o[b]},  {31'd0, |(s & m_irq[b])});
            check({tag, " R4 fiq"},  {31'd0, fiq_o[b]},  {31'd0, |(s & m_fiq[b])});
            check({tag, " R5 endp"}, {31'd0, endp_o[b]}, {31'd0, |(s & m_endp[b])});
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] held;
        for (int b = 0; b < NB; b++) begin
            m_irq[b] = '0; m_fiq[b] = '0; m_endp[b] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 irq_o", {30'd0, irq_o}, 32'h0);
        check("R1 fiq_o", {30'd0, fiq_o}, 32'h0);
        check("R1 endp_o", {30'd0, endp_o}, 32'h0);
        for (int b = 0; b < NB; b++) begin
            for (int o = 0; o < 4; o++) begin
                bus_read(AW'(b*16 + o*4), rd);
                check("R1 reg", rd, 32'h0);
            end
        end

        // R2 latency: after one edge the cause is not yet visible, after two it is
        @(negedge clk);
        src = 64'h1;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 8'h00;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
        check("R2 latency early", bus_rdata, 32'h0);
        bus_read(8'h00, rd);
        check("R2 latency late", rd, 32'h1);
        apply_src('0);

        // R6 mask writes and readback
        set_masks(0, 32'h5555_5555, 32'haaaa_aaaa, 32'h0000_ffff);
        set_masks(1, 32'h0f0f_0f0f, 32'hf0f0_f0f0, 32'hffff_0000);
        for (int b = 0; b < NB; b++) begin
            bus_read(AW'(b*16 + 4), rd);  check("R6 irq mask readback", rd, m_irq[b]);
            bus_read(AW'(b*16 + 8), rd);  check("R6 fiq mask readback", rd, m_fiq[b]);
            bus_read(AW'(b*16 + 12), rd); check("R6 endp mask readback", rd, m_endp[b]);
        end

        // R2/R9/R3/R4/R5: walk a single source through every bit of every bank
        for (int b = 0; b < NB; b++) begin
            for (int i = 0; i < 32; i++) begin
                logic [NB*32-1:0] v;
                v = '0;
                v[b*32 + i] = 1'b1;
                apply_src(v);
                bus_read(AW'(b*16), rd);
                check("R2 cause walk", rd, 32'h1 << i);
                bus_read(AW'((1 - b)*16), rd);
                check("R9 other bank cause", rd, 32'h0);
                check_lines("walk");
            end
        end

        // multi-bit patterns computed arithmetically
        for (int k = 0; k < 16; k++) begin
            logic [31:0] p;
            p = 32'h9e37_79b9 * (k + 1);
            apply_src({p ^ 32'h1234_5678, p});
            bus_read(8'h10, rd);
            check("R2 pattern bank1", rd, p ^ 32'h1234_5678);
            check_lines("pattern");
        end

        // R2: level held with no acknowledge stays visible
        apply_src({32'h0, 32'h8000_0001});
        repeat (5) @(negedge clk);
        bus_read(8'h00, rd);
        check("R2 held no ack", rd, 32'h8000_0001);

        // R7: writes to cause ignored
        bus_write(8'h00, 32'hffff_ffff);
        bus_read(8'h00, rd);
        check("R7 cause after write", rd, 32'h8000_0001);
        bus_read(8'h04, rd);
        check("R7 irq mask untouched", rd, m_irq[0]);
        check_lines("R7");

        // R8: unmapped reads and writes
        bus_read(8'h02, rd); check("R8 misaligned read", rd, 32'h0);
        bus_read(8'h14, rd); held = rd;
        bus_read(8'h24, rd); check("R8 bank out of range read", rd, 32'h0);
        bus_read(8'h1d, rd); check("R8 odd offset read", rd, 32'h0);
        bus_write(8'h24, 32'h1111_1111);
        bus_write(8'h05, 32'h2222_2222);
        bus_read(8'h04, rd); check("R8 bank0 irq mask untouched", rd, m_irq[0]);
        bus_read(8'h14, rd); check("R8 bank1 irq mask untouched", rd, held);

        // R10: read data holds without read strobe
        bus_read(8'h08, rd);
        held = rd;
        repeat (4) @(negedge clk);
        check("R10 hold idle", bus_rdata, held);
        bus_write(8'h08, 32'h0000_0001);
        m_fiq[0] = 32'h0000_0001;
        check("R10 hold across write", bus_rdata, held);
        check_lines("R10");

        // R6: zero normal mask disables the normal line
        apply_src({32'hffff_ffff, 32'hffff_ffff});
        check("R6 irq high before disable", {31'd0, irq_o[0]}, 32'h1);
        bus_write(8'h04, 32'h0);
        m_irq[0] = 32'h0;
        check("R6 irq low after zero mask", {31'd0, irq_o[0]}, 32'h0);
        check("R9 bank1 irq unaffected", {31'd0, irq_o[1]}, 32'h1);
        check_lines("R6");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule